// File: doc/BRIEF.md
# Clock Divider Search and Configuration Word Builder

This block turns a requested core frequency, given in whole MHz, and a serial link baud rate into two 32-bit configuration words for a hashing die. Starting from a fixed 25 MHz reference, it walks the PLL input divider upward one step per clock. At each step it derives the feedback multiplier and stops on the first pair whose output frequency comes close enough to the request. If the output frequency falls below the value reached at the previous step, it stops and falls back to that previous pair. The chosen pair is packed into a clock-control word.

While the search runs, a restoring divider computes how many core clock periods fit into one serial bit. That count is packed into a core-control word. Both words are published together with a one-cycle done pulse and are held until the next completed request.

The interface is plain control. A start pulse seen while the block is idle latches the request and raises busy. The block has no back-pressure and no queue. A start that arrives while busy is high is dropped, and the requester must wait for done before it issues another request.

Top module: `pll_cfg_builder`

## Requirements
- R1: While reset is held and just after it is released, busy and done are 0 and both output words are 0.
- R2: A start seen while idle raises busy in the next cycle and captures target_mhz and baud. A start seen while busy is ignored, and the result that follows belongs to the first request.
- R3: For divider d, tried in the order 1, 2, ... 32, the multiplier is m = floor(target × d / 25), limited to at most 128.
- R4: If the output frequency 25·m/d at divider d is strictly below the value at divider d−1, the search ends with the pair from d−1.
- R5: Otherwise, the search ends at the current pair as soon as 25·m/d > target − 0.5, which is evaluated exactly as 50·m > (2·target − 1)·d.
- R6: If neither R4 nor R5 ends the search by d = 32, the pair from d = 32 is used.
- R7: The clock word holds (m − 1) mod 128 in bits 27:21 and d − 1 in bits 20:16. Bits 31, 2 and 0 are 1 and every other bit is 0, so the word is 0x80000005 with the two fields ORed in.
- R8: The core word's bits 15:0 hold floor(target × 1,000,000 / baud) mod 65536. A baud of 0 yields 0xFFFF.
- R9: Bits 31 and 30 of the core word are 1 and bits 29:16 are 0.
- R10: done is a one-cycle pulse. busy falls in the same cycle that done rises, no more than 33 cycles after the start was taken. The output words change only at done and hold their values until the next done, whatever happens on the inputs in between.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request pulse, taken only while idle |
| target_mhz | input | TGT_W (10) | Requested core frequency in MHz |
| baud | input | BAUD_W (24) | Serial bit rate in bits per second |
| busy | output | 1 | A request is being processed |
| done | output | 1 | One-cycle pulse when both words are updated |
| clk_word | output | 32 | Clock-control configuration word |
| core_word | output | 32 | Core-control configuration word |

## Verification
Take k as the edge that samples an accepted start. The search needs n steps (1 ≤ n ≤ 32) and the divider needs 30 steps, so done and the new words appear after edge k + max(n, 30) + 1, which is between 31 and 33 cycles later. The bench counts falling edges from k until done is seen, checks that busy stayed high on each of them, and reads both words in that same sample. It then looks one cycle later to confirm the done pulse has ended. The sweep covers every target from 0 to 1023 against a rotating set of baud rates that includes 1 and 0. Every kind of search exit is included, along with multiplier clamping.

// File: rtl/pllcfg_pkg.sv
package pllcfg_pkg;

  localparam int WORD_W   = 32;
  localparam int MF_W     = 7;   // multiplier field in the clock word
  localparam int DF_W     = 5;   // divider field in the clock word
  localparam int RPT_W    = 16;  // report-cycle field in the core word

  // Clock word: bypass=1, band=0, outdiv=0, mult-1, div-1, zeros, reconfig=1, enable=1
  function automatic logic [WORD_W-1:0] pack_clk_word(input logic [MF_W-1:0] mfld,
                                                      input logic [DF_W-1:0] dfld);
    return {1'b1, 1'b0, 2'b00, mfld, dfld, 9'd0, 4'd0, 1'b1, 1'b0, 1'b1};
  endfunction

  // Core word: force start=1, serial enable=1, debug=0, byte order=0, report cycles
  function automatic logic [WORD_W-1:0] pack_core_word(input logic [RPT_W-1:0] rpt);
    return {1'b1, 1'b1, 1'b0, 1'b0, 12'd0, rpt};
  endfunction

endpackage

// File: rtl/pll_div_search.sv
module pll_div_search #(
  parameter int TGT_W    = 10,
  parameter int REF_MHZ  = 25,
  parameter int DIV_MAX  = 32,
  parameter int MULT_MAX = 128,
  parameter int MF_W     = 7,
  parameter int DF_W     = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [TGT_W-1:0] target,
  output logic             rdy,
  output logic [MF_W-1:0]  mult_fld,
  output logic [DF_W-1:0]  div_fld
);

  localparam int DIV_W = $clog2(DIV_MAX + 1);
  localparam int MUL_W = $clog2(MULT_MAX + 1);
  localparam int ACC_W = TGT_W + DIV_W;
  localparam int PRD_W = MUL_W + DIV_W;
  localparam int REF2W = MUL_W + $clog2(2 * REF_MHZ + 1);
  localparam int CMP_W = ((ACC_W > REF2W) ? ACC_W : REF2W) + 2;

  typedef enum logic {S_IDLE, S_RUN} st_t;

  st_t              st_q;
  logic [TGT_W-1:0] tgt_q;
  logic [DIV_W-1:0] d_q;
  logic [ACC_W-1:0] acc_q;     // target * d, kept by accumulation
  logic [MUL_W-1:0] pm_q;
  logic [DIV_W-1:0] pd_q;
  logic             hp_q;
  logic             rdy_q;
  logic [MF_W-1:0]  mf_q;
  logic [DF_W-1:0]  df_q;

  logic [ACC_W-1:0] quo;
  logic [MUL_W-1:0] m_cur;
  logic [PRD_W-1:0] prev_x, cur_x;
  logic [CMP_W-1:0] near_l, near_r;
  logic             drop, near, last;

  always_comb begin
    quo    = acc_q / ACC_W'(REF_MHZ);
    m_cur  = (quo > ACC_W'(MULT_MAX)) ? MUL_W'(MULT_MAX) : quo[MUL_W-1:0];
    // previous rate > current rate, cross-multiplied
    prev_x = PRD_W'(pm_q) * PRD_W'(d_q);
    cur_x  = PRD_W'(m_cur) * PRD_W'(pd_q);
    drop   = hp_q && (prev_x > cur_x);
    // 2*REF*m + d > 2*target*d  <=>  REF*m/d > target - 1/2
    near_l = CMP_W'(2 * REF_MHZ) * CMP_W'(m_cur) + CMP_W'(d_q);
    near_r = CMP_W'(2) * CMP_W'(tgt_q) * CMP_W'(d_q);
    near   = near_l > near_r;
    last   = (d_q == DIV_W'(DIV_MAX));
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      tgt_q <= '0;
      d_q   <= '0;
      acc_q <= '0;
      pm_q  <= '0;
      pd_q  <= '0;
      hp_q  <= 1'b0;
      rdy_q <= 1'b0;
      mf_q  <= '0;
      df_q  <= '0;
    end else if (start) begin
      st_q  <= S_RUN;
      tgt_q <= target;
      d_q   <= DIV_W'(1);
      acc_q <= ACC_W'(target);
      hp_q  <= 1'b0;
      rdy_q <= 1'b0;
    end else if (st_q == S_RUN) begin
      if (drop) begin
        mf_q  <= MF_W'(pm_q - MUL_W'(1));
        df_q  <= DF_W'(pd_q - DIV_W'(1));
        rdy_q <= 1'b1;
        st_q  <= S_IDLE;
      end else if (near || last) begin
        mf_q  <= MF_W'(m_cur - MUL_W'(1));
        df_q  <= DF_W'(d_q - DIV_W'(1));
        rdy_q <= 1'b1;
        st_q  <= S_IDLE;
      end else begin
        pm_q  <= m_cur;
        pd_q  <= d_q;
        hp_q  <= 1'b1;
        d_q   <= d_q + DIV_W'(1);
        acc_q <= acc_q + ACC_W'(tgt_q);
      end
    end
  end

  assign rdy      = rdy_q;
  assign mult_fld = mf_q;
  assign div_fld  = df_q;

endmodule

// File: rtl/rcyc_divider.sv
module rcyc_divider #(
  parameter int NUM_W = 30,
  parameter int DEN_W = 24,
  parameter int OUT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [NUM_W-1:0] numer,
  input  logic [DEN_W-1:0] denom,
  output logic             rdy,
  output logic [OUT_W-1:0] quot
);

  localparam int CNT_W = $clog2(NUM_W + 1);

  logic [NUM_W-1:0] num_q;
  logic [DEN_W-1:0] den_q;
  logic [DEN_W-1:0] rem_q;
  logic [OUT_W-1:0] q_q;      // only the low quotient bits are kept
  logic [CNT_W-1:0] cnt_q;
  logic             run_q;
  logic             rdy_q;

  logic [DEN_W:0] trial, diff;
  logic           ge;

  always_comb begin
    trial = {rem_q, num_q[NUM_W-1]};
    diff  = trial - {1'b0, den_q};
    ge    = trial >= {1'b0, den_q};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      num_q <= '0;
      den_q <= '0;
      rem_q <= '0;
      q_q   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      rdy_q <= 1'b0;
    end else if (start) begin
      num_q <= numer;
      den_q <= denom;
      rem_q <= '0;
      q_q   <= '0;
      cnt_q <= CNT_W'(NUM_W);
      run_q <= 1'b1;
      rdy_q <= 1'b0;
    end else if (run_q) begin
      num_q <= {num_q[NUM_W-2:0], 1'b0};
      rem_q <= ge ? diff[DEN_W-1:0] : trial[DEN_W-1:0];
      q_q   <= {q_q[OUT_W-2:0], ge};
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        run_q <= 1'b0;
        rdy_q <= 1'b1;
      end
    end
  end

  assign rdy  = rdy_q;
  assign quot = q_q;

endmodule

// File: rtl/pll_cfg_builder.sv
module pll_cfg_builder
  import pllcfg_pkg::*;
#(
  parameter int TGT_W      = 10,
  parameter int BAUD_W     = 24,
  parameter int REF_MHZ    = 25,
  parameter int DIV_MAX    = 32,
  parameter int MULT_MAX   = 128,
  parameter int HZ_PER_MHZ = 1000000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [TGT_W-1:0]  target_mhz,
  input  logic [BAUD_W-1:0] baud,
  output logic              busy,
  output logic              done,
  output logic [31:0]       clk_word,
  output logic [31:0]       core_word
);

  localparam int NUM_W   = TGT_W + $clog2(HZ_PER_MHZ);
  localparam int LAT_MAX = ((DIV_MAX > NUM_W) ? DIV_MAX : NUM_W) + 1;

  logic             busy_q, done_q;
  logic [31:0]      cw_q, kw_q;
  logic             go;
  logic             s_rdy, d_rdy;
  logic [MF_W-1:0]  mfld;
  logic [DF_W-1:0]  dfld;
  logic [RPT_W-1:0] rpt;
  logic [NUM_W-1:0] numer;

  assign go    = start && !busy_q;
  assign numer = NUM_W'(target_mhz) * NUM_W'(HZ_PER_MHZ);

  pll_div_search #(
    .TGT_W(TGT_W), .REF_MHZ(REF_MHZ), .DIV_MAX(DIV_MAX),
    .MULT_MAX(MULT_MAX), .MF_W(MF_W), .DF_W(DF_W)
  ) u_search (
    .clk(clk), .rst_n(rst_n), .start(go), .target(target_mhz),
    .rdy(s_rdy), .mult_fld(mfld), .div_fld(dfld)
  );

  rcyc_divider #(
    .NUM_W(NUM_W), .DEN_W(BAUD_W), .OUT_W(RPT_W)
  ) u_div (
    .clk(clk), .rst_n(rst_n), .start(go), .numer(numer), .denom(baud),
    .rdy(d_rdy), .quot(rpt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      cw_q   <= '0;
      kw_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (go) begin
        busy_q <= 1'b1;
      end else if (busy_q && s_rdy && d_rdy) begin
        busy_q <= 1'b0;
        done_q <= 1'b1;
        cw_q   <= pack_clk_word(mfld, dfld);
        kw_q   <= pack_core_word(rpt);
      end
    end
  end

  assign busy      = busy_q;
  assign done      = done_q;
  assign clk_word  = cw_q;
  assign core_word = kw_q;

endmodule

// File: rtl/pll_cfg_checker.sv
module pll_cfg_checker #(
  parameter int LAT_MAX = 33
) (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        busy,
  input logic        done,
  input logic [31:0] clk_word,
  input logic [31:0] core_word
);

  localparam int LC_W = $clog2(LAT_MAX + 2);

  logic [LC_W-1:0] lat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) lat_q <= '0;
    else if (busy && lat_q != {LC_W{1'b1}}) lat_q <= lat_q + LC_W'(1);
    else if (!busy) lat_q <= '0;
  end

  AST_START_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy);                                         // R2
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);                                                    // R10
  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy);                                                    // R10
  AST_BUSY_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);                                              // R10
  AST_CLK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(clk_word) |-> done);                                       // R10
  AST_CORE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(core_word) |-> done);                                      // R10
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (lat_q < LC_W'(LAT_MAX)));                                 // R10
  AST_CLK_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (clk_word[31:28] == 4'h8 && clk_word[15:0] == 16'h0005));  // R7
  AST_CORE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (core_word[31:16] == 16'hC000));                           // R9

endmodule

bind pll_cfg_builder pll_cfg_checker #(.LAT_MAX(LAT_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done),
  .clk_word(clk_word), .core_word(core_word)
);

// File: tb/test_pll_cfg_builder.sv
module test_pll_cfg_builder;

  localparam int TGT_W  = 10;
  localparam int BAUD_W = 24;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              start = 1'b0;
  logic [TGT_W-1:0]  tgt = '0;
  logic [BAUD_W-1:0] baud = '0;
  logic              busy, done;
  logic [31:0]       cw, kw;

  int  n_chk = 0;
  int  n_fail = 0;
  bit  ended = 1'b0;

  always #4 clk = ~clk;

  pll_cfg_builder i_pll_cfg_builder (
    .clk(clk), .rst_n(rst_n), .start(start), .target_mhz(tgt), .baud(baud),
    .busy(busy), .done(done), .clk_word(cw), .core_word(kw)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  endtask

  // Expected search result from R3..R6; path 1 = drop, 2 = window, 3 = end of range
  task automatic model(input int t, output logic [31:0] w, output int path);
    int pm, pd, m, fm, fd;
    bit hp;
    pm = 0; pd = 0; hp = 0; fm = 0; fd = 0; path = 0;
    for (int d = 1; d <= 32; d++) begin
      m = (t * d) / 25;
      if (m > 128) m = 128;
      if (hp && pm * d > m * pd) begin fm = pm; fd = pd; path = 1; break; end
      if (50 * m > (2 * t - 1) * d) begin fm = m; fd = d; path = 2; break; end
      if (d == 32) begin fm = m; fd = d; path = 3; break; end
      pm = m; pd = d; hp = 1;
    end
    w = 32'h8000_0005 | (32'((fm - 1) & 127) << 21) | (32'((fd - 1) & 31) << 16);
  endtask

  function automatic logic [31:0] exp_core(input int t, input int b);
    longint q;
    if (b == 0) q = 'hFFFF;
    else q = (longint'(t) * 1000000) / b;
    return 32'hC000_0000 | 32'(q & 'hFFFF);
  endfunction

  function automatic int pick_baud(input int t);
    case (t % 6)
      0: return 115200;
      1: return 9600;
      2: return 1;
      3: return 0;
      4: return 57600;
      default: return 3000000;
    endcase
  endfunction

  task automatic launch(input int t, input int b);
    @(negedge clk);
    tgt = TGT_W'(t);
    baud = BAUD_W'(b);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int c, output bit busy_ok);
    c = 0;
    busy_ok = 1'b1;
    while (!done && c < 100) begin
      if (!busy) busy_ok = 1'b0;
      @(negedge clk);
      c++;
    end
  endtask

  initial begin
    #(8 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog R10 actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    int c, path;
    bit bok;
    logic [31:0] ew, ek, hold_cw, hold_kw;
    string tag;

    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!busy && !done && cw == 0 && kw == 0, "R1 during reset", {busy, done, cw[29:0]}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && cw == 0 && kw == 0, "R1 after reset", {busy, done, cw[29:0]}, 0);

    // Full sweep of targets (R3..R10)
    for (int t = 0; t < 1024; t++) begin
      launch(t, pick_baud(t));
      wait_done(c, bok);
      chk(c >= 1 && c <= 33 && bok && !busy, "R10 latency/busy", 32'(c), 32'd33);
      model(t, ew, path);
      case (path)
        1:       tag = "R3 R4 R7 drop revert";
        2:       tag = "R3 R5 R7 window hit";
        default: tag = "R3 R6 R7 last divider";
      endcase
      chk(cw == ew, tag, cw, ew);
      ek = exp_core(t, pick_baud(t));
      chk(kw == ek, "R8 R9 core word", kw, ek);
      @(negedge clk);
      chk(!done, "R10 done pulse", {31'd0, done}, 0);
    end

    // R2: second start while busy is dropped
    launch(37, 115200);
    repeat (4) @(negedge clk);
    chk(busy, "R2 busy after start", {31'd0, busy}, 1);
    tgt = TGT_W'(910);
    baud = BAUD_W'(9600);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(c, bok);
    model(37, ew, path);
    chk(cw == ew, "R2 clock word of first request", cw, ew);
    ek = exp_core(37, 115200);
    chk(kw == ek, "R2 core word of first request", kw, ek);

    // R10: words hold without a start
    hold_cw = cw;
    hold_kw = kw;
    tgt = TGT_W'(500);
    baud = BAUD_W'(1);
    repeat (40) @(negedge clk);
    chk(cw == hold_cw && !busy, "R10 clock word hold", cw, hold_cw);
    chk(kw == hold_kw, "R10 core word hold", kw, hold_kw);

    finish_run();
  end

endmodule